// File: doc/BRIEF.md
# Cascadable Serial Fault Readout

This block keeps a two-bit fault code for each of four load channels and lets a host read all of them over a three-wire serial link. Fault detectors elsewhere on the chip report a fault by pulsing a per-channel valid strobe together with a code. The host pulls the active-low select pin low to capture the codes into a shift register, then clocks them out one bit per serial clock on an open-drain data line. Several devices can sit in one chain: the chain input of each device feeds the bits of the next device in behind its own frame.

While the device is deselected, the data line works as a fault-pending flag: it is pulled low whenever any channel holds a code other than "no fault". Releasing the select pin clears every stored code. Faults that arrive while a readout is in progress are held back and merged into the store at that release, so the frame on the wire never changes mid-read and no fault is lost. All select, serial clock and chain pins are sampled by a fast system clock through synchronizers.

Top module: `fault_chain_reader`

## Requirements
- R1: Codes are two bits: 2'b11 no fault, 2'b00 overload or shorted load, 2'b10 open load, 2'b01 short to ground. A pulse on `flt_vld[i]` stores `flt_code[2i+1:2i]` for channel i.
- R2: A new strobe on a channel replaces whatever code that channel held before.
- R3: While deselected, `rd_pull_lo` is 1 in the cycle after any stored code differs from 2'b11, and 0 while all codes are 2'b11.
- R4: `sel_n`, `shclk` and `chain_in` pass through two synchronizer flops; the frame is captured at the third system clock edge that samples `sel_n` low, and the line shows the idle flag until then.
- R5: The frame is sent most significant bit first, channel 0 in D7:D6, channel 1 in D5:D4, channel 2 in D3:D2, channel 3 in D1:D0, bit 1 of each code before bit 0; during readout `rd_pull_lo` is the inverse of the current frame bit.
- R6: Each synchronized falling edge of `shclk` during readout moves the next bit onto the line.
- R7: `chain_in` is sampled at each synchronized rising edge of `shclk` and enters the register's low end, so bits clocked in appear on the line after the eight local bits.
- R8: A synchronized rising edge of `sel_n` resets every channel code to 2'b11.
- R9: Strobes during readout do not alter the frame being read; they are held and become the channel codes at the release edge, a strobe in the release cycle itself taking precedence.
- R10: `clr_n` low at a clock edge sets every code to 2'b11 and discards held faults, ahead of any strobe or release.
- R11: After `rst`, all codes are 2'b11 and `rd_pull_lo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_n | input | 1 | Synchronous active-low clear of all fault codes |
| sel_n | input | 1 | Active-low select pin of the serial link |
| shclk | input | 1 | Serial shift clock pin |
| chain_in | input | 1 | Serial data from the next device in the chain |
| flt_vld | input | 4 | Per-channel fault report strobe |
| flt_code | input | 8 | Reported codes, channel i in bits [2i+1:2i] |
| rd_pull_lo | output | 1 | Open-drain enable; 1 pulls the data line low |

## Verification
Assertions watch, every cycle, that a clear empties the store, that codes hold still while a read is under way, that an empty release leaves all codes at "no fault", that a direct strobe overwrites its channel, and that the shift register loads the frame and shifts in the held chain bit. Only the bench scenarios show the whole path from pins to line: the synchronizer latency on select, the bit order of a full frame followed by chained bits, a fault deferred through a read and seen on the next one, and the flag dropping on release.

// File: rtl/flt_pkg.sv
package flt_pkg;

    localparam int CODE_W = 2;

    typedef enum logic [CODE_W-1:0] {
        FC_OVERLOAD   = 2'b00,
        FC_GND_SHORT  = 2'b01,
        FC_OPEN       = 2'b10,
        FC_NONE       = 2'b11
    } fcode_e;

    typedef struct packed {
        logic   vld;
        fcode_e code;
    } pend_t;

    localparam pend_t PEND_EMPTY = '{vld: 1'b0, code: FC_NONE};

    function automatic logic is_fault(input fcode_e c);
        return c != FC_NONE;
    endfunction

endpackage

// File: rtl/flt_sync.sv
module flt_sync #(
    parameter int           W       = 3,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[s] <= RST_VAL;
            else     stg[s] <= stg[s-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/flt_edge.sv
module flt_edge #(
    parameter int           W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= RST_VAL;
        else     prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;
endmodule

// File: rtl/flt_store.sv
module flt_store
    import flt_pkg::*;
#(
    parameter int NCH = 4,
    localparam int FW = NCH * CODE_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr_n,
    input  logic [NCH-1:0] flt_vld,
    input  logic [FW-1:0]  flt_code,
    input  logic           cs_rise,
    input  logic           defer,
    output logic [FW-1:0]  frame,
    output logic           any_fault
);
    fcode_e err_q  [NCH];
    pend_t  pend_q [NCH];
    logic   pend_any;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        fcode_e fresh;
        assign fresh = fcode_e'(flt_code[CODE_W*i +: CODE_W]);

        always_ff @(posedge clk) begin
            if (rst || !clr_n) begin
                err_q[i]  <= FC_NONE;
                pend_q[i] <= PEND_EMPTY;
            end else if (cs_rise) begin
                if (flt_vld[i])          err_q[i] <= fresh;
                else if (pend_q[i].vld)  err_q[i] <= pend_q[i].code;
                else                     err_q[i] <= FC_NONE;
                pend_q[i] <= PEND_EMPTY;
            end else if (defer) begin
                if (flt_vld[i]) pend_q[i] <= '{vld: 1'b1, code: fresh};
            end else if (flt_vld[i]) begin
                err_q[i] <= fresh;
            end
        end

        assign frame[FW-1-CODE_W*i -: CODE_W] = err_q[i];
    end

    always_comb begin
        any_fault = 1'b0;
        pend_any  = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            any_fault = any_fault | is_fault(err_q[i]);
            pend_any  = pend_any  | pend_q[i].vld;
        end
    end

    // R10: a clear leaves every code at no-fault and nothing held
    p_clear_wipes_r10: assert property (@(posedge clk) disable iff (rst)
        !clr_n |=> (frame == '1) && !pend_any);

    // R9: codes do not move while a read is in progress
    p_frozen_read_r9: assert property (@(posedge clk) disable iff (rst)
        (defer && !cs_rise && clr_n) |=> $stable(frame));

    // R8: release with nothing held and no strobe leaves all codes clear
    p_release_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (cs_rise && clr_n && !pend_any && (flt_vld == '0)) |=> (frame == '1));

    // R2: a direct strobe on channel 0 replaces its code
    p_overwrite_r2: assert property (@(posedge clk) disable iff (rst)
        (clr_n && !cs_rise && !defer && flt_vld[0])
        |=> (frame[FW-1 -: CODE_W] == $past(flt_code[CODE_W-1:0])));
endmodule

// File: rtl/flt_shift.sv
module flt_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cs_fall,
    input  logic         cs_rise,
    input  logic         sclk_rise,
    input  logic         sclk_fall,
    input  logic         chain_s,
    input  logic [W-1:0] frame,
    output logic         rd_act,
    output logic         out_bit
);
    logic [W-1:0] sr_q;
    logic         hold_q;
    logic         rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q   <= '1;
            hold_q <= 1'b1;
            rd_q   <= 1'b0;
        end else begin
            if (sclk_rise) hold_q <= chain_s;
            if (cs_fall) begin
                sr_q <= frame;
                rd_q <= 1'b1;
            end else if (cs_rise) begin
                rd_q <= 1'b0;
            end else if (rd_q && sclk_fall) begin
                sr_q <= {sr_q[W-2:0], hold_q};
            end
        end
    end

    assign rd_act  = rd_q;
    assign out_bit = sr_q[W-1];

    // R5: the select edge captures the current frame and starts a read
    p_capture_r5: assert property (@(posedge clk) disable iff (rst)
        cs_fall |=> rd_q && (sr_q == $past(frame)));

    // R6 / R7: a clock fall shifts left and pulls in the held chain bit
    p_shift_chain_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_q && sclk_fall && !cs_fall && !cs_rise)
        |=> (sr_q == {$past(sr_q[W-2:0]), $past(hold_q)}));
endmodule

// File: rtl/fault_chain_reader.sv
module fault_chain_reader
    import flt_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int SYNC_STAGES = 2,
    localparam int FW         = NCH * CODE_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr_n,
    input  logic           sel_n,
    input  logic           shclk,
    input  logic           chain_in,
    input  logic [NCH-1:0] flt_vld,
    input  logic [FW-1:0]  flt_code,
    output logic           rd_pull_lo
);
    // bit 0 select, bit 1 serial clock, bit 2 chain data
    logic [2:0] pin_s;
    logic [1:0] rise, fall;
    logic [FW-1:0] frame;
    logic any_fault, rd_act, out_bit, defer;

    flt_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b101)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({chain_in, shclk, sel_n}),
        .dout (pin_s)
    );

    flt_edge #(.W(2), .RST_VAL(2'b01)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (pin_s[1:0]),
        .rise (rise),
        .fall (fall)
    );

    assign defer = rd_act | fall[0];

    flt_store #(.NCH(NCH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .clr_n     (clr_n),
        .flt_vld   (flt_vld),
        .flt_code  (flt_code),
        .cs_rise   (rise[0]),
        .defer     (defer),
        .frame     (frame),
        .any_fault (any_fault)
    );

    flt_shift #(.W(FW)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .cs_fall   (fall[0]),
        .cs_rise   (rise[0]),
        .sclk_rise (rise[1]),
        .sclk_fall (fall[1]),
        .chain_s   (pin_s[2]),
        .frame     (frame),
        .rd_act    (rd_act),
        .out_bit   (out_bit)
    );

    always_comb begin
        if (rd_act) rd_pull_lo = ~out_bit;
        else        rd_pull_lo = any_fault;
    end

    // R11: the line is released in the first cycle after reset
    p_reset_idle_r11: assert property (@(posedge clk)
        $fell(rst) |-> !rd_pull_lo);
endmodule

// File: tb/sim_fault_chain_reader.sv
module sim_fault_chain_reader;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clr_n = 1'b1;
    logic       sel_n = 1'b1;
    logic       shclk = 1'b0;
    logic       chain_in = 1'b1;
    logic [3:0] flt_vld = '0;
    logic [7:0] flt_code = '0;
    logic       rd_pull_lo;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fault_chain_reader u0 (
        .clk        (clk),
        .rst        (rst),
        .clr_n      (clr_n),
        .sel_n      (sel_n),
        .shclk      (shclk),
        .chain_in   (chain_in),
        .flt_vld    (flt_vld),
        .flt_code   (flt_code),
        .rd_pull_lo (rd_pull_lo)
    );

    // ---------------- behavioural reference ----------------
    bit cs_h[$], ck_h[$], di_h[$];
    int m_err[4];
    int m_pv[4];
    int m_pc[4];
    bit m_rd;
    bit m_sr[$];
    bit m_hold;

    task automatic model_reset();
        cs_h = '{1'b1, 1'b1, 1'b1};
        ck_h = '{1'b0, 1'b0, 1'b0};
        di_h = '{1'b1, 1'b1, 1'b1};
        for (int i = 0; i < 4; i++) begin
            m_err[i] = 3; m_pv[i] = 0; m_pc[i] = 3;
        end
        m_rd = 1'b0;
        m_sr = {};
        for (int i = 0; i < 8; i++) m_sr.push_back(1'b1);
        m_hold = 1'b1;
    endtask

    function automatic bit model_line();
        bit f = 1'b0;
        if (m_rd) return !m_sr[0];
        for (int i = 0; i < 4; i++) if (m_err[i] != 3) f = 1'b1;
        return f;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            model_reset();
        end else begin
            bit cf, cr, kr, kf, hold_n;
            bit snap[$];
            cf = !cs_h[1] && cs_h[2];
            cr = cs_h[1] && !cs_h[2];
            kr = ck_h[1] && !ck_h[2];
            kf = !ck_h[1] && ck_h[2];
            snap = {};
            for (int i = 0; i < 4; i++) begin
                snap.push_back(m_err[i][1]);
                snap.push_back(m_err[i][0]);
            end
            if (!clr_n) begin
                for (int i = 0; i < 4; i++) begin m_err[i] = 3; m_pv[i] = 0; end
            end else if (cr) begin
                for (int i = 0; i < 4; i++) begin
                    if (flt_vld[i]) m_err[i] = int'(flt_code[2*i +: 2]);
                    else if (m_pv[i] != 0) m_err[i] = m_pc[i];
                    else m_err[i] = 3;
                    m_pv[i] = 0;
                end
            end else if (m_rd || cf) begin
                for (int i = 0; i < 4; i++)
                    if (flt_vld[i]) begin m_pv[i] = 1; m_pc[i] = int'(flt_code[2*i +: 2]); end
            end else begin
                for (int i = 0; i < 4; i++)
                    if (flt_vld[i]) m_err[i] = int'(flt_code[2*i +: 2]);
            end
            hold_n = kr ? di_h[1] : m_hold;
            if (cf) begin
                m_sr = snap; m_rd = 1'b1;
            end else if (cr) begin
                m_rd = 1'b0;
            end else if (m_rd && kf) begin
                void'(m_sr.pop_front());
                m_sr.push_back(m_hold);
            end
            m_hold = hold_n;
            cs_h.push_front(sel_n);    void'(cs_h.pop_back());
            ck_h.push_front(shclk);    void'(ck_h.pop_back());
            di_h.push_front(chain_in); void'(di_h.pop_back());
        end
    end

    // per-cycle comparison against the reference
    always @(posedge clk) begin
        #3;
        if (!rst && !done) begin
            checks++;
            if (rd_pull_lo !== model_line()) begin
                failures++;
                $display("FAIL R4 per-cycle line model: act=%0b exp=%0b at %0t",
                         rd_pull_lo, model_line(), $time);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe(input int ch, input logic [1:0] code);
        @(negedge clk);
        flt_vld[ch] = 1'b1;
        flt_code[2*ch +: 2] = code;
        @(negedge clk);
        flt_vld = '0;
    endtask

    // full read of 16 bits; optional strobe on channel mid_ch during bit 3
    task automatic readout(input logic [7:0] casc, input int mid_ch,
                           input logic [1:0] mid_code, output logic [15:0] got);
        sel_n = 1'b0;
        tick(10);
        for (int k = 0; k < 16; k++) begin
            got[15-k] = !rd_pull_lo;
            chain_in = (k < 8) ? casc[7-k] : 1'b1;
            if (k == 3 && mid_ch >= 0) begin
                flt_vld[mid_ch] = 1'b1;
                flt_code[2*mid_ch +: 2] = mid_code;
                tick(1);
                flt_vld = '0;
                tick(1);
            end else begin
                tick(2);
            end
            shclk = 1'b1;
            tick(8);
            shclk = 1'b0;
            tick(8);
        end
        sel_n = 1'b1;
        tick(6);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog: act=%0d exp=%0d", 200000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---------------- scenarios ----------------
    initial begin
        logic [15:0] got;
        tick(5);
        rst = 1'b0;
        tick(2);
        chk(rd_pull_lo == 1'b0, "R11 reset line released", rd_pull_lo, 0);

        // R1 / R3: open load on channel 1 raises the idle flag
        strobe(1, 2'b10);
        chk(rd_pull_lo == 1'b1, "R3 flag after fault", rd_pull_lo, 1);

        // R2: replace with short to ground; overload on channel 3
        strobe(1, 2'b01);
        strobe(3, 2'b00);
        readout(8'hA5, -1, 2'b11, got);
        chk(got[15:8] == 8'hDC, "R5 R6 R1 R2 frame order", got[15:8], 8'hDC);
        chk(got[7:0] == 8'hA5, "R7 chained bits", got[7:0], 8'hA5);
        chk(rd_pull_lo == 1'b0, "R8 release clears", rd_pull_lo, 0);

        readout(8'h3C, -1, 2'b11, got);
        chk(got[15:8] == 8'hFF, "R8 empty frame after release", got[15:8], 8'hFF);
        chk(got[7:0] == 8'h3C, "R7 chained bits second pattern", got[7:0], 8'h3C);

        // R9: fault during read is deferred
        readout(8'h00, 2, 2'b10, got);
        chk(got[15:8] == 8'hFF, "R9 frame unchanged by late fault", got[15:8], 8'hFF);
        chk(got[7:0] == 8'h00, "R7 chained zeros", got[7:0], 8'h00);
        chk(rd_pull_lo == 1'b1, "R9 deferred fault flagged after release", rd_pull_lo, 1);
        readout(8'hFF, -1, 2'b11, got);
        chk(got[15:8] == 8'hFB, "R9 deferred fault read next time", got[15:8], 8'hFB);
        chk(rd_pull_lo == 1'b0, "R8 cleared after second read", rd_pull_lo, 0);

        // R4: capture happens at the third edge seeing select low
        strobe(3, 2'b00);
        sel_n = 1'b0;
        tick(2);
        chk(rd_pull_lo == 1'b1, "R4 flag held before capture", rd_pull_lo, 1);
        tick(1);
        chk(rd_pull_lo == 1'b0, "R4 frame bit D7 after capture", rd_pull_lo, 0);
        sel_n = 1'b1;
        tick(6);
        chk(rd_pull_lo == 1'b0, "R8 release after short select", rd_pull_lo, 0);

        // R10: clear input wipes codes
        strobe(0, 2'b00);
        chk(rd_pull_lo == 1'b1, "R3 overload on channel 0", rd_pull_lo, 1);
        clr_n = 1'b0;
        tick(1);
        clr_n = 1'b1;
        tick(1);
        chk(rd_pull_lo == 1'b0, "R10 clear wipes codes", rd_pull_lo, 0);
        readout(8'h81, -1, 2'b11, got);
        chk(got[15:8] == 8'hFF, "R10 frame empty after clear", got[15:8], 8'hFF);

        tick(4);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule